// File: doc/BRIEF.md
# Fetch Stall Request Generator

This block decides when instruction fetch must pause. It watches two sources of back-pressure from the memory side. The first is a return queue whose write and read pointers each carry one extra wrap bit. When the queue holds too many entries, the block raises a request. The second is a block-store operation that waits for an issue slot. The block counts how many cycles in a row it waits, and once that count is exhausted it raises a request that stays up until the other memory traffic clears.

The queue request is combined with a skid-buffer stall input and a forced thread-switch input to form the memory-side request. That request, the starvation request and a raw external request are merged and registered once to drive the fetch stall line. The queue storage itself is not part of this block: only its pointers come in.

Top module: `fetch_stall_gen`

## Requirements
- R1: Queue occupancy is the write pointer minus the read pointer, modulo 2^PTR_W (default PTR_W=6, where bit 5 is the wrap bit). A read pointer numerically above the write pointer therefore yields a small positive occupancy, and equal pointers yield zero.
- R2: The queue request is high exactly when occupancy is at least OCC_THRESH (default 4). An occupancy of 3 gives no request and an occupancy of 4 gives one.
- R3: `mem_stall_req` is the same-cycle OR of the queue request, `skid_stall` and `force_switch`.
- R4: The wait counter (CNT_W bits, default 6) clears on every cycle in which `bst_pending` is low. One idle cycle before saturation therefore restarts the full count of 2^CNT_W−1 pending edges.
- R5: `starve_req` is set on the clock edge at which the counter holds all ones, `bst_pending` is high and `bst_can_issue` is low. If `bst_can_issue` is high in that cycle, the request is not set.
- R6: Once set, `starve_req` stays high on every edge at which `other_mem_op` is high. It drops on the first edge at which `other_mem_op` is low, unless the set condition of R5 holds again on that edge.
- R7: `fetch_stall` is the OR of `mem_stall_req`, `starve_req` and `raw_stall_req`, registered one cycle.
- R8: While `rst_n` is low, `starve_req`, `fetch_stall` and the wait counter are cleared on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_wr_ptr | input | PTR_W | Return queue write pointer, with its wrap bit as the MSB |
| q_rd_ptr | input | PTR_W | Return queue read pointer, with its wrap bit as the MSB |
| skid_stall | input | 1 | Stall request from the skid buffer |
| force_switch | input | 1 | Forced thread-switch request |
| bst_pending | input | 1 | A block store is waiting to issue |
| bst_can_issue | input | 1 | The waiting block store may issue this cycle |
| other_mem_op | input | 1 | Another memory operation is in progress |
| raw_stall_req | input | 1 | External stall request, passed through to fetch |
| mem_stall_req | output | 1 | Combinational memory-side request |
| starve_req | output | 1 | Registered block-store starvation request |
| fetch_stall | output | 1 | Registered stall to instruction fetch |

## Verification
Two requests can become active together. The queue request can rise in the same cycle in which the starvation request first sets. The starvation request can also be held by `other_mem_op` while the queue request or the raw input toggles. The bench provokes the first case by taking the counter to saturation while the pointers sit at the threshold. It then confirms that `fetch_stall` rises one edge after the queue request and remains high after the queue drains, while starvation is still held. The second case is judged by dropping `other_mem_op` and seeing `fetch_stall` fall one edge after `starve_req`.

// File: rtl/fetch_stall_gen.sv
module fetch_stall_gen #(
  parameter int PTR_W      = 6,
  parameter int OCC_THRESH = 4,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] q_wr_ptr,
  input  logic [PTR_W-1:0] q_rd_ptr,
  input  logic             skid_stall,
  input  logic             force_switch,
  input  logic             bst_pending,
  input  logic             bst_can_issue,
  input  logic             other_mem_op,
  input  logic             raw_stall_req,
  output logic             mem_stall_req,
  output logic             starve_req,
  output logic             fetch_stall
);
  localparam logic [PTR_W-1:0] THR   = PTR_W'(OCC_THRESH);
  localparam logic [CNT_W-1:0] SAT   = {CNT_W{1'b1}};

  logic [PTR_W-1:0] occ;
  logic             q_full;
  logic [CNT_W-1:0] wait_cnt;
  logic             starve_set;

  assign occ           = q_wr_ptr - q_rd_ptr;
  assign q_full        = (occ >= THR);
  assign mem_stall_req = q_full | skid_stall | force_switch;
  assign starve_set    = (wait_cnt == SAT) & bst_pending & ~bst_can_issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt    <= '0;
      starve_req  <= 1'b0;
      fetch_stall <= 1'b0;
    end else begin
      wait_cnt    <= bst_pending ? wait_cnt + 1'b1 : '0;
      starve_req  <= starve_set | (starve_req & other_mem_op);
      fetch_stall <= mem_stall_req | starve_req | raw_stall_req;
    end
  end
endmodule

// File: rtl/fetch_stall_gen_chk.sv
module fetch_stall_gen_chk #(
  parameter int PTR_W      = 6,
  parameter int OCC_THRESH = 4,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] q_wr_ptr,
  input logic [PTR_W-1:0] q_rd_ptr,
  input logic             skid_stall,
  input logic             force_switch,
  input logic             bst_pending,
  input logic             bst_can_issue,
  input logic             other_mem_op,
  input logic             raw_stall_req,
  input logic             mem_stall_req,
  input logic             starve_req,
  input logic             fetch_stall
);
  logic [CNT_W-1:0] run_len;
  logic [PTR_W-1:0] fill;
  logic             at_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= bst_pending ? run_len + 1'b1 : '0;
  end

  assign fill   = q_wr_ptr - q_rd_ptr;
  assign at_sat = (run_len == {CNT_W{1'b1}}) && bst_pending;

  AST_QUEUE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) >= OCC_THRESH) |-> mem_stall_req); // R2
  AST_QUEUE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(fill) < OCC_THRESH) && !skid_stall && !force_switch) |-> !mem_stall_req); // R3
  AST_STARVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sat && !bst_can_issue) |=> starve_req); // R5
  AST_STARVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (starve_req && other_mem_op) |=> starve_req); // R6
  AST_STARVE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (starve_req && !other_mem_op && !(at_sat && !bst_can_issue)) |=> !starve_req); // R6
  AST_STARVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!starve_req && !(at_sat && !bst_can_issue)) |=> !starve_req); // R4
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stall_req || mem_stall_req || starve_req) |=> fetch_stall); // R7
  AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_stall_req && !mem_stall_req && !starve_req) |=> !fetch_stall); // R7
endmodule

bind fetch_stall_gen fetch_stall_gen_chk #(
  .PTR_W(PTR_W), .OCC_THRESH(OCC_THRESH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .q_wr_ptr(q_wr_ptr), .q_rd_ptr(q_rd_ptr),
  .skid_stall(skid_stall), .force_switch(force_switch),
  .bst_pending(bst_pending), .bst_can_issue(bst_can_issue),
  .other_mem_op(other_mem_op), .raw_stall_req(raw_stall_req),
  .mem_stall_req(mem_stall_req), .starve_req(starve_req),
  .fetch_stall(fetch_stall)
);

// File: tb/sim_fetch_stall_gen.sv
module sim_fetch_stall_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] q_wr_ptr = '0, q_rd_ptr = '0;
  logic       skid_stall = 1'b0, force_switch = 1'b0;
  logic       bst_pending = 1'b0, bst_can_issue = 1'b0, other_mem_op = 1'b0;
  logic       raw_stall_req = 1'b0;
  logic       mem_stall_req, starve_req, fetch_stall;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  fetch_stall_gen u0 (
    .clk(clk), .rst_n(rst_n), .q_wr_ptr(q_wr_ptr), .q_rd_ptr(q_rd_ptr),
    .skid_stall(skid_stall), .force_switch(force_switch),
    .bst_pending(bst_pending), .bst_can_issue(bst_can_issue),
    .other_mem_op(other_mem_op), .raw_stall_req(raw_stall_req),
    .mem_stall_req(mem_stall_req), .starve_req(starve_req),
    .fetch_stall(fetch_stall)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    raw_stall_req = 1'b1;
    bst_pending = 1'b1;
    tick(3);
    chk("R8 fetch_stall in reset", fetch_stall, 1'b0);
    chk("R8 starve_req in reset", starve_req, 1'b0);
    raw_stall_req = 1'b0;
    bst_pending = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R8 fetch_stall after reset", fetch_stall, 1'b0);
  endtask

  task automatic t_queue;
    q_rd_ptr = 6'b011110; q_wr_ptr = 6'b100001; #1;
    chk("R2 occ 3 no request", mem_stall_req, 1'b0);
    q_wr_ptr = 6'b100010; #1;
    chk("R2 occ 4 request", mem_stall_req, 1'b1);
    tick();
    chk("R7 queue request registered", fetch_stall, 1'b1);
    q_rd_ptr = 6'b111111; q_wr_ptr = 6'b000011; #1;
    chk("R1 wrapped occ 4", mem_stall_req, 1'b1);
    q_wr_ptr = 6'b000010; #1;
    chk("R1 wrapped occ 3", mem_stall_req, 1'b0);
    q_wr_ptr = q_rd_ptr; #1;
    chk("R1 equal pointers empty", mem_stall_req, 1'b0);
    tick();
    chk("R7 fetch_stall falls", fetch_stall, 1'b0);
  endtask

  task automatic t_or;
    skid_stall = 1'b1; #1;
    chk("R3 skid stall", mem_stall_req, 1'b1);
    skid_stall = 1'b0; force_switch = 1'b1; #1;
    chk("R3 forced switch", mem_stall_req, 1'b1);
    tick();
    chk("R7 forced switch registered", fetch_stall, 1'b1);
    force_switch = 1'b0; #1;
    chk("R3 all clear", mem_stall_req, 1'b0);
    tick();
  endtask

  task automatic t_raw;
    raw_stall_req = 1'b1; #1;
    chk("R7 raw not yet visible", fetch_stall, 1'b0);
    tick();
    chk("R7 raw registered", fetch_stall, 1'b1);
    raw_stall_req = 1'b0;
    tick();
    chk("R7 raw released", fetch_stall, 1'b0);
  endtask

  task automatic t_starve;
    bst_pending = 1'b1; bst_can_issue = 1'b0;
    tick(63);
    chk("R5 no request before saturation", starve_req, 1'b0);
    q_rd_ptr = 6'd0; q_wr_ptr = 6'd4;
    tick();
    chk("R5 request at saturation", starve_req, 1'b1);
    chk("R7 queue and starvation same cycle", fetch_stall, 1'b1);
    q_wr_ptr = 6'd0;
    bst_pending = 1'b0; other_mem_op = 1'b1;
    tick(3);
    chk("R6 held by other op", starve_req, 1'b1);
    chk("R7 held starvation keeps stall", fetch_stall, 1'b1);
    other_mem_op = 1'b0;
    tick();
    chk("R6 drops without other op", starve_req, 1'b0);
    tick();
    chk("R7 stall drops after starvation", fetch_stall, 1'b0);
  endtask

  task automatic t_clear;
    bst_pending = 1'b1; bst_can_issue = 1'b0;
    tick(62);
    bst_pending = 1'b0;
    tick();
    bst_pending = 1'b1;
    tick(63);
    chk("R4 idle cycle restarted count", starve_req, 1'b0);
    tick();
    chk("R4 full count reaches request", starve_req, 1'b1);
    bst_pending = 1'b0;
    tick();
    chk("R6 drop after clear run", starve_req, 1'b0);
    tick();
  endtask

  task automatic t_can_issue;
    bst_pending = 1'b1; bst_can_issue = 1'b1;
    tick(64);
    chk("R5 can issue blocks request", starve_req, 1'b0);
    chk("R5 no fetch stall", fetch_stall, 1'b0);
    bst_pending = 1'b0; bst_can_issue = 1'b0;
    tick();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_queue();
    t_or();
    t_raw();
    t_starve();
    t_clear();
    t_can_issue();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule